// File: doc/BRIEF.md
# Four-Cell Programmable Logic Fabric with Serial Configuration Loader

This block is a very small reconfigurable logic array. It has four logic cells placed on a 2x2 grid and five switch boxes between them. Each logic cell has a 2-input look-up table, a flip-flop and an output select. Each switch box holds six fixed connection points. One serial bitstream of fixed length sets the logic and the routing of the whole array. It has no partial form: every cell and every switch box receives a word, including the ones a mapping does not use.

Three user pins reach the cell inputs only through switch boxes. The single user output is also picked through a switch box. A three-input function is built by chaining two cells. The first cell combines two pins. Its result is routed to a second cell, which combines it with the third pin. Loading a new bitstream replaces the function without any other action.

Top module: `mini_fabric`

## Requirements
- R1: A bit on `cfg_din` is accepted on a rising `cfg_clk` edge while `cfg_en` is 1. The stream is 50 bits long and is sent MSB first. Its order is cell 0, cell 1, cell 2, cell 3 (5 bits each), then switch box 0 to 4 (6 bits each). Inside each word the most significant bit is sent first.
- R2: `cfg_done` is 0 after reset and stays 0 through the 49th accepted bit. It is 1 from the clock edge that accepts the 50th bit.
- R3: `usr_out` is 0 whenever `cfg_done` is 0.
- R4: While `cfg_en` is 0, `cfg_din` has no effect. Both the configuration and `cfg_done` keep their values.
- R5: A bit accepted while `cfg_done` is 1 starts a new load. `cfg_done` falls, and that bit counts as the first bit of the new stream.
- R6: Cell word bits [3:0] form a truth table. The cell's combinational value is bit {a,b}, with input a as the more significant index bit.
- R7: When cell word bit 4 is 1, the cell output comes from its flip-flop. The flip-flop loads the table value on a rising `usr_clk` edge while `cfg_done` is 1. When bit 4 is 0, the cell output is the table value directly.
- R8: Bit k of a switch box word enables its k-th connection. Pins P0..P2 are `usr_in[0..2]`, Cn is the output of cell n, and An/Bn are the a/b inputs of cell n. The connections are:
  - SB0: P0-A0, P0-A1, P0-A2, P0-B3, C1-A2, C2-A3
  - SB1: P1-B0, P1-B1, P1-B2, P1-B3, C0-B2, C1-B3
  - SB2: P2-B1, P2-B3, P2-A2, P2-A3, C0-B3, C1-A3
  - SB3: C0-A1, C2-A3, C1-B2, C0-A3, C2-B3, C1-A2
  - SB4: C0, C1, C2, C3, P0, P2 to the output
- R9: A cell input with no enabled connection reads 0. An input reached by several enabled connections reads the OR of their sources.
- R10: When the switch box 4 word is all zero, `usr_out` is 0 even after `cfg_done` is 1.
- R11: Reset clears the configuration, the bit count and every cell flip-flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_en | input | 1 | Accept the serial bit on this edge |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| cfg_done | output | 1 | A complete bitstream is loaded |
| usr_clk | input | 1 | Clock of the cell flip-flops |
| usr_in | input | 3 | User input pins P0..P2 |
| usr_out | output | 1 | User output pin |

## Verification
The bench targets the places where an off-by-one slip would hide:
- It checks `cfg_done` between the 49th and 50th bits. A counter that stops one bit early or late would shift every word by one position and corrupt the LUT tables.
- It reloads over a running configuration with idle gaps inside the stream. A loader that ignored a restart would keep `cfg_done` high, and one that shifted with `cfg_en` low would misplace the words.
- It loads an asymmetric truth table, which catches swapped a/b indexing.
- It changes a pin between a clock edge and the sample point. A cell that bypassed its flip-flop would follow the pin at once.
- It maps one input through two connections to check the OR merge.
- It loads a stream that routes nothing, which shows that unconnected inputs read 0 and that an empty output box yields 0.

// File: rtl/fab_pkg.sv
`timescale 1ns/1ps
package fab_pkg;
  localparam int NUM_CELL   = 4;
  localparam int NUM_SB     = 5;
  localparam int NUM_PIN    = 3;
  localparam int LUT_IN     = 2;
  localparam int LUT_SIZE   = 1 << LUT_IN;
  localparam int CELL_W     = LUT_SIZE + 1;
  localparam int SB_W       = 6;
  localparam int CELL_BITS  = NUM_CELL * CELL_W;
  localparam int SB_BITS    = NUM_SB * SB_W;
  localparam int STREAM_LEN = CELL_BITS + SB_BITS;
  localparam int CNT_W      = $clog2(STREAM_LEN + 1);
  localparam int NODE_W     = 4;
  localparam int NODE_CNT   = 1 << NODE_W;

  // source codes: pins 0..2, cell outputs 3..6
  localparam logic [NODE_W-1:0] S_P0 = 4'd0, S_P1 = 4'd1, S_P2 = 4'd2;
  localparam logic [NODE_W-1:0] S_C0 = 4'd3, S_C1 = 4'd4, S_C2 = 4'd5, S_C3 = 4'd6;
  // sink codes: 2*cell + (0 = a, 1 = b), 8 = user output
  localparam logic [NODE_W-1:0] D_A0 = 4'd0, D_B0 = 4'd1, D_A1 = 4'd2, D_B1 = 4'd3;
  localparam logic [NODE_W-1:0] D_A2 = 4'd4, D_B2 = 4'd5, D_A3 = 4'd6, D_B3 = 4'd7;
  localparam logic [NODE_W-1:0] D_OUT = 4'd8;

  typedef struct packed {
    logic [NODE_W-1:0] src;
    logic [NODE_W-1:0] dst;
  } link_t;

  // Fixed connection of switch box sb, bit k. Cell sources only feed
  // higher-numbered cells, so the fabric can never close a combinational loop.
  function automatic link_t sb_link(input int sb, input int k);
    link_t l;
    case (sb * SB_W + k)
      0:  l = '{src: S_P0, dst: D_A0};
      1:  l = '{src: S_P0, dst: D_A1};
      2:  l = '{src: S_P0, dst: D_A2};
      3:  l = '{src: S_P0, dst: D_B3};
      4:  l = '{src: S_C1, dst: D_A2};
      5:  l = '{src: S_C2, dst: D_A3};
      6:  l = '{src: S_P1, dst: D_B0};
      7:  l = '{src: S_P1, dst: D_B1};
      8:  l = '{src: S_P1, dst: D_B2};
      9:  l = '{src: S_P1, dst: D_B3};
      10: l = '{src: S_C0, dst: D_B2};
      11: l = '{src: S_C1, dst: D_B3};
      12: l = '{src: S_P2, dst: D_B1};
      13: l = '{src: S_P2, dst: D_B3};
      14: l = '{src: S_P2, dst: D_A2};
      15: l = '{src: S_P2, dst: D_A3};
      16: l = '{src: S_C0, dst: D_B3};
      17: l = '{src: S_C1, dst: D_A3};
      18: l = '{src: S_C0, dst: D_A1};
      19: l = '{src: S_C2, dst: D_A3};
      20: l = '{src: S_C1, dst: D_B2};
      21: l = '{src: S_C0, dst: D_A3};
      22: l = '{src: S_C2, dst: D_B3};
      23: l = '{src: S_C1, dst: D_A2};
      24: l = '{src: S_C0, dst: D_OUT};
      25: l = '{src: S_C1, dst: D_OUT};
      26: l = '{src: S_C2, dst: D_OUT};
      27: l = '{src: S_C3, dst: D_OUT};
      28: l = '{src: S_P0, dst: D_OUT};
      29: l = '{src: S_P2, dst: D_OUT};
      default: l = '{src: S_P0, dst: 4'd15};
    endcase
    return l;
  endfunction
endpackage

// File: rtl/fab_rst_sync.sv
`timescale 1ns/1ps
module fab_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/fab_cfg_loader.sv
`timescale 1ns/1ps
module fab_cfg_loader
  import fab_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_en,
  input  logic                  din,
  output logic [STREAM_LEN-1:0] cfg_word,
  output logic                  done
);
  logic [STREAM_LEN-1:0] sr_q, sr_n;
  logic [CNT_W-1:0]      cnt_q, cnt_n;
  logic                  done_q, done_n;

  always_comb begin
    sr_n   = sr_q;
    cnt_n  = cnt_q;
    done_n = done_q;
    if (shift_en) begin
      sr_n = {sr_q[STREAM_LEN-2:0], din};
      if (done_q) begin
        cnt_n  = CNT_W'(1);
        done_n = 1'b0;
      end else begin
        cnt_n  = cnt_q + 1'b1;
        done_n = (cnt_q == CNT_W'(STREAM_LEN - 1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      sr_q   <= sr_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  assign cfg_word = sr_q;
  assign done     = done_q;

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> ($stable(sr_q) && $stable(done_q) && $stable(cnt_q)));
  a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && shift_en) |=> !done_q);
  a_r2_done_on_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(shift_en) && ($past(cnt_q) == CNT_W'(STREAM_LEN - 1))));
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(STREAM_LEN));
endmodule

// File: rtl/fab_cell_bank.sv
`timescale 1ns/1ps
module fab_cell_bank
  import fab_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en,
  input  logic [NUM_CELL-1:0] d,
  output logic [NUM_CELL-1:0] q
);
  logic [NUM_CELL-1:0] q_q, q_n;

  generate
    for (genvar c = 0; c < NUM_CELL; c++) begin : g_cell_ff
      always_comb q_n[c] = cap_en ? d[c] : q_q[c];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q[c] <= 1'b0;
        else        q_q[c] <= q_n[c];
      end
    end
  endgenerate

  assign q = q_q;

  a_r7_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(q_q));
endmodule

// File: rtl/fab_route.sv
`timescale 1ns/1ps
module fab_route
  import fab_pkg::*;
(
  input  logic [STREAM_LEN-1:0] cfg_word,
  input  logic [NUM_PIN-1:0]    pins,
  input  logic [NUM_CELL-1:0]   cell_q,
  output logic [NUM_CELL-1:0]   cell_d,
  output logic                  raw_out
);
  logic [LUT_SIZE-1:0] lut_tab [NUM_CELL];
  logic [NUM_CELL-1:0] reg_sel;
  logic [SB_W-1:0]     sb_cfg  [NUM_SB];

  generate
    for (genvar c = 0; c < NUM_CELL; c++) begin : g_cell_cfg
      localparam int TOP = STREAM_LEN - 1 - c * CELL_W;
      assign reg_sel[c] = cfg_word[TOP];
      assign lut_tab[c] = cfg_word[TOP-1 -: LUT_SIZE];
    end
    for (genvar s = 0; s < NUM_SB; s++) begin : g_sb_cfg
      assign sb_cfg[s] = cfg_word[SB_BITS - 1 - s * SB_W -: SB_W];
    end
  endgenerate

  logic [NODE_CNT-1:0] node;
  logic                in_a, in_b, out_acc;
  link_t               lk;

  // Cells evaluate in index order; routing only feeds forward.
  always_comb begin
    node          = '0;
    node[NUM_PIN-1:0] = pins;
    cell_d        = '0;
    in_a          = 1'b0;
    in_b          = 1'b0;
    out_acc       = 1'b0;
    lk            = '0;
    for (int c = 0; c < NUM_CELL; c++) begin
      in_a = 1'b0;
      in_b = 1'b0;
      for (int s = 0; s < NUM_SB; s++) begin
        for (int k = 0; k < SB_W; k++) begin
          lk = sb_link(s, k);
          if (sb_cfg[s][k] && (lk.dst == NODE_W'(2 * c)))     in_a = in_a | node[lk.src];
          if (sb_cfg[s][k] && (lk.dst == NODE_W'(2 * c + 1))) in_b = in_b | node[lk.src];
        end
      end
      cell_d[c] = lut_tab[c][{in_a, in_b}];
      node[NUM_PIN + c] = reg_sel[c] ? cell_q[c] : cell_d[c];
    end
    for (int s = 0; s < NUM_SB; s++) begin
      for (int k = 0; k < SB_W; k++) begin
        lk = sb_link(s, k);
        if (sb_cfg[s][k] && (lk.dst == D_OUT)) out_acc = out_acc | node[lk.src];
      end
    end
  end

  assign raw_out = out_acc;

  always_comb begin
    if (sb_cfg[NUM_SB-1] == '0) a_r10_empty_out_box: assert (raw_out == 1'b0);
  end
endmodule

// File: rtl/mini_fabric.sv
`timescale 1ns/1ps
module mini_fabric
  import fab_pkg::*;
(
  input  logic               rst_n,
  input  logic               cfg_clk,
  input  logic               cfg_en,
  input  logic               cfg_din,
  output logic               cfg_done,
  input  logic               usr_clk,
  input  logic [NUM_PIN-1:0] usr_in,
  output logic               usr_out
);
  logic                  cfg_rst_n, usr_rst_n;
  logic [STREAM_LEN-1:0] cfg_word;
  logic                  done;
  logic [NUM_CELL-1:0]   cell_d, cell_q;
  logic                  raw_out;

  fab_rst_sync u_cfg_rst (.clk(cfg_clk), .arst_n(rst_n), .srst_n(cfg_rst_n));
  fab_rst_sync u_usr_rst (.clk(usr_clk), .arst_n(rst_n), .srst_n(usr_rst_n));

  fab_cfg_loader u_loader (
    .clk(cfg_clk), .rst_n(cfg_rst_n), .shift_en(cfg_en), .din(cfg_din),
    .cfg_word(cfg_word), .done(done)
  );

  fab_cell_bank u_cells (
    .clk(usr_clk), .rst_n(usr_rst_n), .cap_en(done), .d(cell_d), .q(cell_q)
  );

  fab_route u_route (
    .cfg_word(cfg_word), .pins(usr_in), .cell_q(cell_q),
    .cell_d(cell_d), .raw_out(raw_out)
  );

  assign cfg_done = done;
  assign usr_out  = done & raw_out;
endmodule

// File: tb/mini_fabric_tb_top.sv
`timescale 1ns/1ps
module mini_fabric_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_en, cfg_din;
  logic       cfg_done, usr_out;
  logic [2:0] usr_in;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic  exp_q [$];
  string tag_q [$];

  always #2.5 clk = ~clk;

  mini_fabric dut_i (
    .rst_n(rst_n), .cfg_clk(clk), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_done(cfg_done), .usr_clk(clk), .usr_in(usr_in), .usr_out(usr_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic logic [49:0] stream(input logic [4:0] c0, input logic [4:0] c1,
      input logic [4:0] c2, input logic [4:0] c3, input logic [5:0] s0,
      input logic [5:0] s1, input logic [5:0] s2, input logic [5:0] s3, input logic [5:0] s4);
    return {c0, c1, c2, c3, s0, s1, s2, s3, s4};
  endfunction

  // R1 R2 R3 R4 R5: serial load, optional idle gaps with toggling data
  task automatic load(input logic [49:0] bs, input bit gaps, input bit reload);
    for (int i = 49; i >= 0; i--) begin
      if (gaps && (i % 7 == 3)) begin
        for (int g = 0; g < 3; g++) begin
          @(negedge clk);
          cfg_en  = 1'b0;
          cfg_din = ~cfg_din;
        end
      end
      @(negedge clk);
      if (i == 0) begin
        check("R2 done low after 49 bits", cfg_done, 1'b0);
        check("R3 output gated while loading", usr_out, 1'b0);
      end
      if (reload && i == 48) check("R5 restart clears done", cfg_done, 1'b0);
      cfg_en  = 1'b1;
      cfg_din = bs[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    check("R2 done after 50th bit", cfg_done, 1'b1);
  endtask

  task automatic drive(input logic [2:0] p, input logic exp, input string tag);
    @(negedge clk);
    usr_in = p;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compares between the capturing edge and the next drive
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() != 0) begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, usr_out, e);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [49:0] fn1, fn2, fn3, fn4, fn5, fn6;
    // fn1: cell0 registered AND(P0,P1); cell1 XOR(C0,P2); out C1
    fn1 = stream(5'b1_1000, 5'b0_0110, 5'b0, 5'b0,
                 6'b000001, 6'b000001, 6'b000001, 6'b000001, 6'b000010);
    // fn2: cell2 registered NAND(P2,P1); cell3 OR(C2,P0); out C3
    fn2 = stream(5'b0, 5'b0, 5'b1_0111, 5'b0_1110,
                 6'b001000, 6'b000100, 6'b000100, 6'b000010, 6'b001000);
    // fn3: cell0 true only at a=0,b=0, nothing routed in; out C0
    fn3 = stream(5'b0_0001, 5'b0, 5'b0, 5'b0,
                 6'b0, 6'b0, 6'b0, 6'b0, 6'b000001);
    // fn4: cell0 true only at a=1,b=0 with a=P0,b=P1; out C0
    fn4 = stream(5'b0_0100, 5'b0, 5'b0, 5'b0,
                 6'b000001, 6'b000001, 6'b0, 6'b0, 6'b000001);
    // fn5: fn4 with an empty output box
    fn5 = stream(5'b0_0100, 5'b0, 5'b0, 5'b0,
                 6'b000001, 6'b000001, 6'b0, 6'b0, 6'b000000);
    // fn6: cell0 passes b=P1; cell1 passes a, a fed by P0 and by C0; out C1
    fn6 = stream(5'b0_1010, 5'b0_1100, 5'b0, 5'b0,
                 6'b000010, 6'b000001, 6'b0, 6'b000001, 6'b000010);

    rst_n = 1'b0; cfg_en = 1'b0; cfg_din = 1'b0; usr_in = 3'b000;
    repeat (3) @(negedge clk);
    check("R11 done low in reset", cfg_done, 1'b0);
    check("R3 output low in reset", usr_out, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 done low after reset", cfg_done, 1'b0);

    load(fn1, 1'b0, 1'b0);
    for (int p = 0; p < 8; p++)
      drive(3'(p), ((p & 1) != 0 && (p & 2) != 0) ^ ((p & 4) != 0), "R1 R6 R7 R8 fn1");
    drain();

    // R7: pin change after the edge must not reach the output until the next edge
    @(negedge clk); usr_in = 3'b011;
    @(posedge clk); #1 usr_in = 3'b010;
    #1 check("R7 registered cell holds", usr_out, 1'b1);
    @(posedge clk); #2 check("R7 registered cell updates", usr_out, 1'b0);

    // R4: idle cycles with toggling data leave the mapping untouched
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); cfg_en = 1'b0; cfg_din = i[0];
    end
    check("R4 done kept while idle", cfg_done, 1'b1);
    for (int p = 7; p >= 0; p--)
      drive(3'(p), ((p & 1) != 0 && (p & 2) != 0) ^ ((p & 4) != 0), "R4 fn1 after idle");
    drain();

    load(fn2, 1'b1, 1'b1);
    for (int p = 0; p < 8; p++)
      drive(3'(p), !((p & 4) != 0 && (p & 2) != 0) || ((p & 1) != 0), "R5 R7 R8 fn2 reload");
    drain();

    load(fn3, 1'b0, 1'b1);
    for (int p = 0; p < 8; p++)
      drive(3'(p), 1'b1, "R9 unconnected inputs read 0");
    drain();

    load(fn4, 1'b0, 1'b1);
    for (int p = 0; p < 8; p++)
      drive(3'(p), ((p & 1) != 0) && ((p & 2) == 0), "R6 a is index MSB");
    drain();

    load(fn5, 1'b0, 1'b1);
    for (int p = 0; p < 8; p++)
      drive(3'(p), 1'b0, "R10 empty output box");
    drain();

    load(fn6, 1'b0, 1'b1);
    for (int p = 0; p < 8; p++)
      drive(3'(p), ((p & 1) != 0) || ((p & 2) != 0), "R9 merged connections OR");
    drain();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule